// File: doc/BRIEF.md
# Distributor Control and Identification Registers

This block is the small register file that sits at the bottom of an interrupt distributor's address map. It decodes three 32-bit registers from address bits [3:2]: a control register holding the global distributor enable, a read-only type register that reports how many interrupt lines and processors the distributor serves, and a read-only identification register carrying a part code and a vendor code.

When software turns the distributor on, that is, when a control write moves the enable from 0 to 1, the block emits a single-cycle notify pulse that the surrounding logic fans out to every processor so each re-examines its pending interrupts. Writing 1 again while already on, or writing 0, produces no pulse. The current enable is also driven out as a plain level for the rest of the distributor.

The register port is a single-cycle request: one request per cycle at most, no back-pressure. The block accepts every request in the cycle it is presented and there is no ready signal. A read answers one cycle later with `rsp_valid` high for exactly one cycle; the requester must take the data in that cycle because nothing is held. Writes produce no response.

Top module: `dist_ctrl_regs`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `enabled`, `notify` and `rsp_valid` are 0, and `rsp_rdata` is 0.
- R2: The register is chosen by `req_addr[3:2]` only: 0 selects control, 1 selects type, 2 selects identification, 3 reads as zero. All other address bits are ignored.
- R3: A write with select 0 loads `req_wdata[0]` into the enable; a control read returns the enable in bit 0 and zeros in bits 31:1. Upper write data bits have no effect.
- R4: A control write that takes the enable from 0 to 1 makes `notify` high for exactly one cycle, in the cycle after the write, the same cycle `enabled` rises.
- R5: A control write of 1 while already enabled, or of 0, leaves `notify` low.
- R6: The type register reads (TOTAL_LINES/32 - 1) in bits [4:0], (`cpu_count` - 1) in bits [7:5], zeros above; `cpu_count` is sampled at the read and lies in 1..8.
- R7: The identification register reads PART_CODE in bits [31:24] and VENDOR_ID in bits [11:0], zeros in bits [23:12].
- R8: Writes with select 1, 2 or 3 change neither `enabled` nor any register read value and never pulse `notify`.
- R9: A read request makes `rsp_valid` high for exactly the next cycle with the data in `rsp_rdata`; a write or an idle cycle leaves `rsp_valid` low and `rsp_rdata` zero in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_count | input | 4 | Number of processors served, 1..8 |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data, zero when `rsp_valid` is low |
| enabled | output | 1 | Current global distributor enable |
| notify | output | 1 | One-cycle pulse on disabled-to-enabled transition |

## Verification
A wrong enable bit shows on `enabled` in the very next cycle and on the next control read one cycle after that, while a mistracked previous enable shows as a missing or extra `notify` pulse in the cycle after the offending write. A decode fault misplaces data: the wrong register's value, or a non-zero value at select 3, appears in `rsp_rdata` on the cycle after the read. Field packing faults in the type register show only for particular processor counts, so every count from 1 to 8 is read back, and every select value is swept across many upper address bits with the enable both off and on.

// File: rtl/dist_ctrl_pkg.sv
package dist_ctrl_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_TYPE  = 2'd1,
    SEL_IDENT = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned DATA_W       = 32;
  localparam int unsigned LINE_GROUP   = 32;
  localparam int unsigned LINE_FIELD_W = 5;
  localparam int unsigned CPU_FIELD_W  = 3;
  localparam int unsigned CPU_CNT_W    = CPU_FIELD_W + 1;
  localparam int unsigned PART_LSB     = 24;
  localparam int unsigned VENDOR_W     = 12;

  function automatic logic [DATA_W-1:0] pack_type(
    input int unsigned          total_lines,
    input logic [CPU_CNT_W-1:0] cpus
  );
    logic [DATA_W-1:0]      v;
    logic [CPU_CNT_W-1:0]   cm1;
    int unsigned            groups;
    groups = total_lines / LINE_GROUP - 1;
    cm1    = cpus - 1'b1;
    v      = '0;
    v[LINE_FIELD_W-1:0] = groups[LINE_FIELD_W-1:0];
    v[LINE_FIELD_W +: CPU_FIELD_W] = cm1[CPU_FIELD_W-1:0];
    return v;
  endfunction

endpackage

// File: rtl/dist_ctrl_decode.sv
module dist_ctrl_decode
  import dist_ctrl_pkg::*;
(
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] word_idx,
  output reg_sel_e   sel,
  output logic       ctrl_wr,
  output logic       rd_req
);
  always_comb begin
    sel     = reg_sel_e'(word_idx);
    ctrl_wr = req_valid && req_write && (sel == SEL_CTRL);
    rd_req  = req_valid && !req_write;
  end
endmodule

// File: rtl/dist_ctrl_enable.sv
module dist_ctrl_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic wr_bit,
  output logic en_q,
  output logic notify_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      notify_q <= 1'b0;
    end else begin
      notify_q <= ctrl_wr && wr_bit && !en_q;
      if (ctrl_wr) en_q <= wr_bit;
    end
  end
endmodule

// File: rtl/dist_ctrl_readmux.sv
module dist_ctrl_readmux
  import dist_ctrl_pkg::*;
#(
  parameter int unsigned    TOTAL_LINES = 96,
  parameter logic [7:0]     PART_CODE   = 8'h5A,
  parameter logic [11:0]    VENDOR_ID   = 12'h3C7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_req,
  input  reg_sel_e             sel,
  input  logic                 en_q,
  input  logic [CPU_CNT_W-1:0] cpu_count,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata
);
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] ident_val;

  always_comb begin
    ident_val = '0;
    ident_val[PART_LSB +: 8]      = PART_CODE;
    ident_val[VENDOR_W-1:0]       = VENDOR_ID;
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:  rd_val = {{(DATA_W-1){1'b0}}, en_q};
      SEL_TYPE:  rd_val = pack_type(TOTAL_LINES, cpu_count);
      SEL_IDENT: rd_val = ident_val;
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? rd_val : '0;
    end
  end
endmodule

// File: rtl/dist_ctrl_regs.sv
module dist_ctrl_regs
  import dist_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned TOTAL_LINES = 96,
  parameter logic [7:0]  PART_CODE   = 8'h5A,
  parameter logic [11:0] VENDOR_ID   = 12'h3C7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CPU_CNT_W-1:0] cpu_count,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 enabled,
  output logic                 notify
);
  reg_sel_e sel;
  logic     ctrl_wr;
  logic     rd_req;
  logic     en_q;
  logic     notify_q;

  logic unused_bits;
  assign unused_bits = &{1'b0, req_addr[ADDR_W-1:4], req_addr[1:0], req_wdata[DATA_W-1:1]};

  dist_ctrl_decode u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .word_idx  (req_addr[3:2]),
    .sel       (sel),
    .ctrl_wr   (ctrl_wr),
    .rd_req    (rd_req)
  );

  dist_ctrl_enable u_enable (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (ctrl_wr),
    .wr_bit   (req_wdata[0]),
    .en_q     (en_q),
    .notify_q (notify_q)
  );

  dist_ctrl_readmux #(
    .TOTAL_LINES (TOTAL_LINES),
    .PART_CODE   (PART_CODE),
    .VENDOR_ID   (VENDOR_ID)
  ) u_readmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .sel       (sel),
    .en_q      (en_q),
    .cpu_count (cpu_count),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign enabled = en_q;
  assign notify  = notify_q;
endmodule

// File: rtl/dist_ctrl_regs_chk.sv
module dist_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  req_sel,
  input logic        wr_bit,
  input logic        enabled,
  input logic        notify,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata
);
  // R4: notify only accompanies a fresh rise of the enable
  p_pulse_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> (enabled && !$past(enabled)));

  // R4: an enabling control write while off always pulses
  p_pulse_follows_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_sel == 2'd0 && wr_bit && !enabled) |=> notify);

  // R5: writing 1 while already on gives no pulse
  p_no_repulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_sel == 2'd0 && enabled) |=> !notify);

  // R8: anything other than a control write leaves the enable alone
  p_enable_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && req_sel == 2'd0) |=> $stable(enabled));

  // R9: reads answer next cycle
  p_rsp_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R9: no response without a read
  p_no_rsp_else_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> (!rsp_valid && rsp_rdata == 32'd0));

  // R3: control read returns the enable seen at the request
  p_ctrl_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_sel == 2'd0) |=> (rsp_rdata == {31'd0, $past(enabled)}));

  // R2: select 3 reads zero
  p_hole_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_sel == 2'd3) |=> (rsp_rdata == 32'd0));
endmodule

bind dist_ctrl_regs dist_ctrl_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_sel   (req_addr[3:2]),
  .wr_bit    (req_wdata[0]),
  .enabled   (enabled),
  .notify    (notify),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata)
);

// File: tb/dist_ctrl_regs_tb_top.sv
module dist_ctrl_regs_tb_top;
  localparam int unsigned TL   = 96;
  localparam logic [7:0]  PART = 8'h5A;
  localparam logic [11:0] VEND = 12'h3C7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cpu_count = 4'd4;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        enabled;
  logic        notify;

  int checks = 0;
  int bad = 0;
  logic exp_en = 1'b0;

  always #5 clk = ~clk;

  dist_ctrl_regs #(.ADDR_W(12), .TOTAL_LINES(TL), .PART_CODE(PART), .VENDOR_ID(VEND)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_count(cpu_count),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .enabled(enabled), .notify(notify)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [11:0] a, input logic [3:0] cpus);
    case (a[3:2])
      2'd0: return {31'd0, exp_en};
      2'd1: return ((TL / 32) - 1) | ((32'(cpus) - 1) << 5);
      2'd2: return (32'(PART) << 24) | 32'(VEND);
      default: return 32'd0;
    endcase
  endfunction

  // write: drive at negedge, sample outputs at next negedge
  task automatic do_write(input logic [11:0] a, input logic [31:0] d,
                          input logic exp_pulse, input string req);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    if (a[3:2] == 2'd0) exp_en = d[0];
    chk({req, " notify"}, {31'd0, notify}, {31'd0, exp_pulse});
    chk({req, " enabled"}, {31'd0, enabled}, {31'd0, exp_en});
    chk("R9 no rsp on write", {rsp_valid, rsp_rdata[30:0]}, 32'd0);
    @(negedge clk);
    chk({req, " pulse one cycle"}, {31'd0, notify}, 32'd0);
  endtask

  task automatic do_read(input logic [11:0] a, input string req);
    logic [31:0] e;
    e = exp_read(a, cpu_count);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(req, rsp_rdata, e);
    @(negedge clk);
    chk("R9 rsp one cycle", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    bad++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 reset", {29'd0, enabled, notify, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {29'd0, enabled, notify, rsp_valid}, 32'd0);
    chk("R1 rdata", rsp_rdata, 32'd0);

    // R2/R6/R7 sweep of addresses with enable off
    for (int i = 0; i < 64; i++) do_read(12'(i * 4 + (i / 4) * 12'h40), "R2 decode off");

    // R6: every processor count
    for (int c = 1; c <= 8; c++) begin
      cpu_count = 4'(c);
      do_read(12'h004, "R6 type");
      do_read(12'hF04, "R6 type alias");
    end
    cpu_count = 4'd3;
    do_read(12'h008, "R7 ident");

    // R4: enable rise pulses
    do_write(12'h000, 32'h0000_0001, 1'b1, "R4 enable rise");
    do_read(12'h000, "R3 ctrl read on");
    // R5: writing 1 again
    do_write(12'h000, 32'hFFFF_FFFF, 1'b0, "R5 rewrite one");
    // R8: writes to type/ident/hole
    do_write(12'h004, 32'h0000_0000, 1'b0, "R8 type write");
    do_write(12'h008, 32'h0000_0000, 1'b0, "R8 ident write");
    do_write(12'h00C, 32'h0000_0000, 1'b0, "R8 hole write");
    do_read(12'h004, "R8 type unchanged");
    do_read(12'h008, "R8 ident unchanged");
    do_read(12'h00C, "R8 hole zero");
    // R5: disable, no pulse
    do_write(12'h100, 32'hFFFF_FFFE, 1'b0, "R5 disable");
    do_read(12'h000, "R3 ctrl read off");
    // R8 writes while off don't enable
    do_write(12'h004, 32'h0000_0001, 1'b0, "R8 type write one");
    do_write(12'h00C, 32'h0000_0001, 1'b0, "R8 hole write one");
    // R3: upper bits ignored, aliased address
    do_write(12'hA30, 32'h0000_0003, 1'b1, "R3 alias enable rise");

    // R2 sweep with enable on
    for (int i = 0; i < 64; i++) do_read(12'(i * 4 + (i / 4) * 12'h40), "R2 decode on");

    // R9 idle cycle: no response
    @(negedge clk);
    chk("R9 idle", {rsp_valid, rsp_rdata[30:0]}, 32'd0);

    // R1: reset again clears enable
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; exp_en = 1'b0;
    @(negedge clk);
    chk("R1 re-reset", {30'd0, enabled, notify}, 32'd0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule